// File: doc/BRIEF.md
# Bidirectional Gate-Scan Shift Register

This block is the logic core of a row driver for an active-matrix display. A single start pulse enters at one end of a chain of one-bit stages and moves one stage on each rising clock edge. Each stage selects one panel row. The scan direction is set by a direction input. A narrow mode takes four middle stages out of the chain, so the same block can serve a panel with four fewer rows.

Three active-high mask lines can blank the rows in a three-phase pattern. This lets the timing controller trim the row-select pulses without disturbing the scan position. When the pulse leaves the far end of the chain, a carry output repeats it half a clock later, on a falling edge, so that a following driver in a cascade can capture it on its next rising edge.

Top module: `gate_scan_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, every stage clears and all rows read low. While `rst` is high at a falling edge, both carry outputs clear.
- R2: With `scan_fwd` = 1, `start_right_in` is sampled on a rising edge and `row_out[0]` (row 1) goes high after that edge. On each later rising edge the pulse moves one row up, toward row 154.
- R3: With `scan_fwd` = 0, `start_left_in` is sampled on a rising edge and `row_out[153]` (row 154) goes high after that edge. On each later rising edge the pulse moves one row down, toward row 1.
- R4: With `narrow_mode` = 1, rows 76 to 79 (`row_out[78:75]`) stay low, and the pulse jumps straight between row 75 and row 80 in one clock. This gives 150 active rows.
- R5: When `row_mask[m]` is high, it forces low every row in phase group m as soon as it is applied, without waiting for a clock edge. Removing the mask brings the row back, because the stage contents are never cleared by masking.
- R6: With `narrow_mode` = 0, row k (1-based) belongs to phase group (k-1) mod 3. So row 1 is gated by bit 0, row 2 by bit 1, row 3 by bit 2, and the pattern repeats.
- R7: With `narrow_mode` = 1, rows 1 to 75 keep the grouping of R6. Row k ≥ 80 belongs to group (k-5) mod 3, so row 80 is gated by bit 0 and row 81 by bit 1.
- R8: The carry output on the far end rises on the falling edge that follows the rising edge that loaded the last active row. Counting from the capture edge, this is the 154th falling edge in wide mode and the 150th in narrow mode. The carry falls on the next falling edge.
- R9: The carry output on the start side of the current direction stays low. This is `carry_right_out` when `scan_fwd` = 1 and `carry_left_out` when `scan_fwd` = 0.
- R10: After a single one-clock start pulse, at most one row is high in any cycle. The high row follows the active-row order exactly, and no row is high once the pulse has left the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages advance on rising edge, carries update on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_fwd | input | 1 | 1: row 1 toward row 154; 0: row 154 toward row 1 |
| narrow_mode | input | 1 | Static configuration; 1 bypasses rows 76 to 79 |
| row_mask | input | 3 | Active-high phase blanking; bit m masks group m |
| start_right_in | input | 1 | Start pulse used when `scan_fwd` = 1 |
| start_left_in | input | 1 | Start pulse used when `scan_fwd` = 0 |
| row_out | output | 154 | Row selects; bit k-1 is row k |
| carry_left_out | output | 1 | Carry to next driver when `scan_fwd` = 1 |
| carry_right_out | output | 1 | Carry to next driver when `scan_fwd` = 0 |

## Verification
The hardest cases to reach are the bypass crossing and the shifted phase grouping after the gap. Both need a pulse that has travelled 75 rows with narrow mode held steady, in each direction. The bench reaches them by running a complete scan for every direction and mode pair, and comparing the whole row vector each cycle.

During one forward scan per mode, it also applies each mask bit between clock edges at every step. This shows that the asynchronous blanking hits exactly the row's own group on both sides of the gap, and that the pulse is still there once the mask is released.

// File: rtl/gate_scan_pkg.sv
`timescale 1ns/1ps
package gate_scan_pkg;
  parameter int unsigned GS_ROWS    = 154; // stages in the full chain
  parameter int unsigned GS_GAP_LO  = 75;  // 0-based index of first bypassed stage
  parameter int unsigned GS_GAP_LEN = 4;   // stages removed in narrow mode
  parameter int unsigned GS_PHASES  = 3;   // mask phase groups
endpackage

// File: rtl/gate_scan_chain.sv
`timescale 1ns/1ps
module gate_scan_chain #(
  parameter int ROWS    = gate_scan_pkg::GS_ROWS,
  parameter int GAP_LO  = gate_scan_pkg::GS_GAP_LO,
  parameter int GAP_LEN = gate_scan_pkg::GS_GAP_LEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_fwd,
  input  logic            narrow,
  input  logic            start_fwd_in,
  input  logic            start_rev_in,
  output logic [ROWS-1:0] stage_q
);
  localparam int GAP_HI = GAP_LO + GAP_LEN - 1;
  localparam int AFTER  = GAP_HI + 1;   // first stage beyond the gap
  localparam int BEFORE = GAP_LO - 1;   // last stage ahead of the gap

  for (genvar i = 0; i < ROWS; i++) begin : g_stage
    localparam bit IS_GAP = (i >= GAP_LO) && (i <= GAP_HI);
    logic from_lo;
    logic from_hi;

    // neighbour feeding this stage in the forward direction
    if (i == 0) begin : g_lo_end
      assign from_lo = start_fwd_in;
    end else if (i == AFTER) begin : g_lo_jump
      assign from_lo = narrow ? stage_q[BEFORE] : stage_q[i-1];
    end else begin : g_lo_mid
      assign from_lo = stage_q[i-1];
    end

    // neighbour feeding this stage in the reverse direction
    if (i == ROWS - 1) begin : g_hi_end
      assign from_hi = start_rev_in;
    end else if (i == BEFORE) begin : g_hi_jump
      assign from_hi = narrow ? stage_q[AFTER] : stage_q[i+1];
    end else begin : g_hi_mid
      assign from_hi = stage_q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst || (IS_GAP && narrow)) stage_q[i] <= 1'b0;
      else                           stage_q[i] <= scan_fwd ? from_lo : from_hi;
    end
  end
endmodule

// File: rtl/gate_scan_gating.sv
`timescale 1ns/1ps
module gate_scan_gating #(
  parameter int ROWS    = gate_scan_pkg::GS_ROWS,
  parameter int GAP_LO  = gate_scan_pkg::GS_GAP_LO,
  parameter int GAP_LEN = gate_scan_pkg::GS_GAP_LEN,
  parameter int PHASES  = gate_scan_pkg::GS_PHASES
) (
  input  logic [ROWS-1:0]   stage_q,
  input  logic              narrow,
  input  logic [PHASES-1:0] row_mask,
  output logic [ROWS-1:0]   row_out
);
  localparam int GAP_HI = GAP_LO + GAP_LEN - 1;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam bit IS_GAP   = (i >= GAP_LO) && (i <= GAP_HI);
    localparam int PH_WIDE  = i % PHASES;
    localparam int PH_NARROW = (i > GAP_HI) ? ((i - GAP_LEN) % PHASES) : (i % PHASES);
    logic blank;
    assign blank      = narrow ? (row_mask[PH_NARROW] | IS_GAP) : row_mask[PH_WIDE];
    assign row_out[i] = stage_q[i] & ~blank;
  end
endmodule

// File: rtl/gate_scan_carry.sv
`timescale 1ns/1ps
module gate_scan_carry (
  input  logic clk,
  input  logic rst,
  input  logic scan_fwd,
  input  logic fwd_end,
  input  logic rev_end,
  output logic carry_fwd_q,
  output logic carry_rev_q
);
  // half-clock carry so the next driver sees it before its rising edge
  always_ff @(negedge clk) begin
    if (rst) begin
      carry_fwd_q <= 1'b0;
      carry_rev_q <= 1'b0;
    end else begin
      carry_fwd_q <= scan_fwd & fwd_end;
      carry_rev_q <= ~scan_fwd & rev_end;
    end
  end
endmodule

// File: rtl/gate_scan_shifter.sv
`timescale 1ns/1ps
module gate_scan_shifter #(
  parameter int ROWS    = gate_scan_pkg::GS_ROWS,
  parameter int GAP_LO  = gate_scan_pkg::GS_GAP_LO,
  parameter int GAP_LEN = gate_scan_pkg::GS_GAP_LEN,
  parameter int PHASES  = gate_scan_pkg::GS_PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_fwd,
  input  logic              narrow_mode,
  input  logic [PHASES-1:0] row_mask,
  input  logic              start_right_in,
  input  logic              start_left_in,
  output logic [ROWS-1:0]   row_out,
  output logic              carry_left_out,
  output logic              carry_right_out
);
  logic [ROWS-1:0] stage_q;

  gate_scan_chain #(.ROWS(ROWS), .GAP_LO(GAP_LO), .GAP_LEN(GAP_LEN)) u_chain (
    .clk          (clk),
    .rst          (rst),
    .scan_fwd     (scan_fwd),
    .narrow       (narrow_mode),
    .start_fwd_in (start_right_in),
    .start_rev_in (start_left_in),
    .stage_q      (stage_q)
  );

  gate_scan_gating #(.ROWS(ROWS), .GAP_LO(GAP_LO), .GAP_LEN(GAP_LEN), .PHASES(PHASES)) u_gating (
    .stage_q  (stage_q),
    .narrow   (narrow_mode),
    .row_mask (row_mask),
    .row_out  (row_out)
  );

  gate_scan_carry u_carry (
    .clk         (clk),
    .rst         (rst),
    .scan_fwd    (scan_fwd),
    .fwd_end     (stage_q[ROWS-1]),
    .rev_end     (stage_q[0]),
    .carry_fwd_q (carry_left_out),
    .carry_rev_q (carry_right_out)
  );
endmodule

// File: rtl/gate_scan_checker.sv
`timescale 1ns/1ps
module gate_scan_checker #(
  parameter int ROWS    = 154,
  parameter int GAP_LO  = 75,
  parameter int GAP_LEN = 4,
  parameter int PHASES  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_fwd,
  input logic              narrow_mode,
  input logic [PHASES-1:0] row_mask,
  input logic [ROWS-1:0]   stage_q,
  input logic [ROWS-1:0]   row_out,
  input logic              carry_left_out,
  input logic              carry_right_out
);
  localparam int GAP_HI = GAP_LO + GAP_LEN - 1;

  // R10
  single_row_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_q));

  // R5
  full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (&row_mask) |-> (row_out == '0));

  // R2
  fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_fwd && $past(scan_fwd) && $past(stage_q[0])) |-> stage_q[1]);

  // R3
  rev_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!scan_fwd && !$past(scan_fwd) && $past(stage_q[ROWS-1])) |-> stage_q[ROWS-2]);

  // R4
  gap_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (narrow_mode && $past(narrow_mode) && scan_fwd && $past(scan_fwd)
     && $past(stage_q[GAP_LO-1])) |-> stage_q[GAP_HI+1]);

  // R4
  gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    narrow_mode |-> (row_out[GAP_HI:GAP_LO] == '0));

  // R8
  carry_src_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_fwd && carry_left_out) |-> stage_q[ROWS-1]);

  // R9
  idle_side_chk: assert property (@(posedge clk) disable iff (rst)
    scan_fwd |-> !carry_right_out);
endmodule

bind gate_scan_shifter gate_scan_checker #(
  .ROWS(ROWS), .GAP_LO(GAP_LO), .GAP_LEN(GAP_LEN), .PHASES(PHASES)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .scan_fwd        (scan_fwd),
  .narrow_mode     (narrow_mode),
  .row_mask        (row_mask),
  .stage_q         (stage_q),
  .row_out         (row_out),
  .carry_left_out  (carry_left_out),
  .carry_right_out (carry_right_out)
);

// File: tb/gate_scan_shifter_bench.sv
`timescale 1ns/1ps
module gate_scan_shifter_bench;
  localparam int N = 154;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_fwd = 1'b1;
  logic         narrow_mode = 1'b0;
  logic [2:0]   row_mask = 3'b000;
  logic         start_right_in = 1'b0;
  logic         start_left_in = 1'b0;
  logic [N-1:0] row_out;
  logic         carry_left_out;
  logic         carry_right_out;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gate_scan_shifter u_gate_scan_shifter (
    .clk(clk), .rst(rst), .scan_fwd(scan_fwd), .narrow_mode(narrow_mode),
    .row_mask(row_mask), .start_right_in(start_right_in), .start_left_in(start_left_in),
    .row_out(row_out), .carry_left_out(carry_left_out), .carry_right_out(carry_right_out)
  );

  function automatic int active_len(input logic nar);
    return nar ? 150 : 154;
  endfunction

  // 1-based row holding the pulse n rising edges after capture (0 if none)
  function automatic int row_at(input int n, input logic fwd, input logic nar);
    int r;
    if (n < 1 || n > active_len(nar)) return 0;
    r = n + ((nar && n > 75) ? 4 : 0);
    return fwd ? r : (155 - r);
  endfunction

  function automatic int group_of(input int r, input logic nar);
    return (nar && r >= 80) ? ((r - 5) % 3) : ((r - 1) % 3);
  endfunction

  function automatic logic [N-1:0] vec_at(input int n, input logic fwd, input logic nar);
    logic [N-1:0] v = '0;
    int r = row_at(n, fwd, nar);
    if (r != 0) v[r-1] = 1'b1;
    return v;
  endfunction

  task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rows actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // R1: reset with a new configuration applied
  task automatic do_reset(input logic fwd, input logic nar);
    rst = 1'b1;
    scan_fwd = fwd;
    narrow_mode = nar;
    row_mask = 3'b000;
    start_right_in = 1'b0;
    start_left_in = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk_vec("R1 rows after reset", row_out, '0);
    @(negedge clk);
    #1 chk_bit("R1 carry_left after reset", carry_left_out, 1'b0);
    chk_bit("R1 carry_right after reset", carry_right_out, 1'b0);
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic launch(input logic fwd);
    if (fwd) start_right_in = 1'b1;
    else     start_left_in = 1'b1;
  endtask

  // R2 R3 R4 R8 R9 R10: full scan, row vector and carries each cycle
  task automatic run_scan(input logic fwd, input logic nar);
    int len = active_len(nar);
    do_reset(fwd, nar);
    launch(fwd);
    for (int n = 1; n <= len + 2; n++) begin
      @(posedge clk);
      #1;
      start_right_in = 1'b0;
      start_left_in = 1'b0;
      chk_vec(fwd ? (nar ? "R4 R2 R10 fwd narrow" : "R2 R10 fwd wide")
                  : (nar ? "R4 R3 R10 rev narrow" : "R3 R10 rev wide"),
              row_out, vec_at(n, fwd, nar));
      @(negedge clk);
      #1;
      chk_bit("R8 far carry", fwd ? carry_left_out : carry_right_out, n == len);
      chk_bit("R9 idle carry", fwd ? carry_right_out : carry_left_out, 1'b0);
    end
  endtask

  // R5 R6 R7: mask each group between edges at every scan step
  task automatic run_masks(input logic nar);
    int len = active_len(nar);
    do_reset(1'b1, nar);
    launch(1'b1);
    for (int n = 1; n <= len; n++) begin
      logic [N-1:0] base;
      int r;
      @(posedge clk);
      #1;
      start_right_in = 1'b0;
      base = vec_at(n, 1'b1, nar);
      r = row_at(n, 1'b1, nar);
      for (int m = 0; m < 3; m++) begin
        row_mask = 3'b001 << m;
        #0.5;
        chk_vec(nar ? "R7 R5 narrow mask" : "R6 R5 wide mask", row_out,
                (group_of(r, nar) == m) ? '0 : base);
      end
      row_mask = 3'b111;
      #0.4;
      chk_vec("R5 all masked", row_out, '0);
      row_mask = 3'b000;
      #0.4;
      chk_vec("R5 unmasked restores", row_out, base);
    end
  endtask

  initial begin
    #(8.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    run_scan(1'b1, 1'b0);
    run_scan(1'b0, 1'b0);
    run_scan(1'b1, 1'b1);
    run_scan(1'b0, 1'b1);
    run_masks(1'b0);
    run_masks(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule